// File: doc/BRIEF.md
# Multi-engine step sequencer

The block walks through a small set of configuration steps, at most four by default. Each step names a set of completion sources: single-channel processing engines, a group of DMA channels chosen by a 3-bit code, an optional CPU handshake and an optional external start event. On entering a step the sequencer sends a one-cycle start pulse to every enabled engine and channel. It then collects their completion pulses, in any order, until every enabled source has reported. It then follows the step's next pointer to the following step.

Software drives the block through simple register-style ports. These are a start pulse, an abort pulse, a step-number write, a step-count limit, and per-step enable masks and next pointers. A zero limit gives manual operation, in which one step runs per start. A nonzero limit runs that many steps and then stops. The block reports whether it is running, which step is current and how many steps have completed.

Top module: `step_seq`

## Requirements
- R1: After reset the block is idle (`running_o`=0), the current step is 0, the executed count is 0 and no start or done pulse is driven.
- R2: A start pulse while idle makes the block running from the next cycle. In that first cycle `step_start_o` is 1 and `eng_start_o` equals the enable mask of the current step, for exactly one cycle.
- R3: The DMA start pulses of a step decode its 3-bit code as a 4-bit channel mask: 0→0000, 1→0011, 2→0111, 3→1111, 4→0001, 5→0010, 6→0100, 7→1000. The same mask selects which DMA done pulses the step waits for.
- R4: A step finishes only once every enabled source has pulsed its done input since the step's entry cycle. Pulses that arrive in the entry cycle or earlier do not count, and pulses on sources that are not enabled are ignored. `step_done_o` is 1 for exactly the cycle in which the last missing pulse arrives.
- R5: A step with no source enabled raises `step_done_o` in the cycle right after its entry cycle.
- R6: When a step finishes and the run continues, the next cycle is the entry cycle of the step named by the finished step's next pointer.
- R7: With a nonzero limit N the block runs N steps after a start and then goes idle. The executed count then reads N, and during the run it reads the number of steps finished so far.
- R8: With a zero limit exactly one step runs, and the block then goes idle with the count at 1 and the current step equal to that step's next pointer.
- R9: An abort pulse while running makes the block idle in the next cycle without `step_done_o`, and the current step stays on the aborted step. An abort pulse while idle changes nothing.
- R10: A start pulse while running is ignored: it issues no new start pulses and does not restart the step or the count.
- R11: A step with external sync enabled also waits for a pulse on `ext_start_i` after its entry cycle. `step_done_o` pulses at the end of every step whether or not the bit is set.
- R12: A step with CPU sync enabled pulses `cpu_start_o` in its entry cycle and cannot finish before a `cpu_done_i` pulse.
- R13: A step-number write while idle sets the current step from the next cycle. Together with a start in the same cycle, the run begins at the written step. A write while running is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse |
| stop_i | input | 1 | Abort pulse |
| step_wr_i | input | 1 | Step-number write strobe |
| step_wdata_i | input | STEP_W | Step number to write |
| step_limit_i | input | CNT_W | Steps per run, 0 = manual single step |
| cfg_eng_en_i | input | NUM_STEPS*NUM_ENG | Engine enable mask per step, step k at [k*NUM_ENG +: NUM_ENG] |
| cfg_dma_code_i | input | NUM_STEPS*3 | DMA code per step, step k at [k*3 +: 3] |
| cfg_cpu_sync_i | input | NUM_STEPS | CPU sync enable per step |
| cfg_ext_sync_i | input | NUM_STEPS | External sync enable per step |
| cfg_next_i | input | NUM_STEPS*STEP_W | Next-step pointer per step, step k at [k*STEP_W +: STEP_W] |
| eng_done_i | input | NUM_ENG | Engine done pulses |
| dma_done_i | input | 4 | DMA channel done pulses |
| cpu_done_i | input | 1 | CPU done write pulse |
| ext_start_i | input | 1 | External step start pulse |
| running_o | output | 1 | 1 while running, 0 when idle |
| cur_step_o | output | STEP_W | Current step number |
| exec_count_o | output | CNT_W | Steps finished in the current or last run |
| eng_start_o | output | NUM_ENG | Engine start pulses |
| dma_start_o | output | 4 | DMA channel start pulses |
| cpu_start_o | output | 1 | CPU start event |
| step_start_o | output | 1 | Pulse in each step's entry cycle |
| step_done_o | output | 1 | Pulse in each step's finishing cycle |

## Verification
The hardest situation to reach is a step whose completion depends on several sources arriving out of order. Some pulses fall in the entry cycle, where they must be dropped. Others repeat, and still others land on disabled sources. All of this happens while software issues start pulses and step writes that the block must ignore. The bench builds random step chains with sparse enable masks and a bench-side pending set, and it injects such noise in every wait cycle. Directed runs cover each DMA code, an abort with sources still pending, an abort while idle, and a start combined with a step write.

// File: rtl/step_seq_pkg.sv
package step_seq_pkg;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int DMA_CH     = 4;
  localparam int DMA_CODE_W = 3;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_ENTER = 2'd1,
    SEQ_WAIT  = 2'd2
  } seq_state_e;

  // 3-bit DMA code to channel mask: groups from channel 0 upward, or one channel
  function automatic logic [DMA_CH-1:0] dma_chan_mask(input logic [DMA_CODE_W-1:0] code);
    logic [DMA_CH-1:0] m;
    case (code)
      3'd1:    m = 4'b0011;
      3'd2:    m = 4'b0111;
      3'd3:    m = 4'b1111;
      3'd4:    m = 4'b0001;
      3'd5:    m = 4'b0010;
      3'd6:    m = 4'b0100;
      3'd7:    m = 4'b1000;
      default: m = 4'b0000;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/step_cfg_sel.sv
module step_cfg_sel
  import step_seq_pkg::*;
#(
  parameter int NUM_STEPS = 4,
  parameter int NUM_ENG   = 6,
  parameter int STEP_W    = 2
) (
  input  logic [STEP_W-1:0]              sel_i,
  input  logic [NUM_STEPS*NUM_ENG-1:0]   cfg_eng_en_i,
  input  logic [NUM_STEPS*DMA_CODE_W-1:0] cfg_dma_code_i,
  input  logic [NUM_STEPS-1:0]           cfg_cpu_sync_i,
  input  logic [NUM_STEPS-1:0]           cfg_ext_sync_i,
  input  logic [NUM_STEPS*STEP_W-1:0]    cfg_next_i,
  output logic [NUM_ENG-1:0]             eng_en_o,
  output logic [DMA_CH-1:0]              dma_en_o,
  output logic                           cpu_en_o,
  output logic                           ext_en_o,
  output logic [STEP_W-1:0]              next_o
);
  timeunit 1ns;
  timeprecision 100ps;

  logic [DMA_CODE_W-1:0] dma_code;

  always_comb begin
    eng_en_o = cfg_eng_en_i[int'(sel_i)*NUM_ENG +: NUM_ENG];
    dma_code = cfg_dma_code_i[int'(sel_i)*DMA_CODE_W +: DMA_CODE_W];
    cpu_en_o = cfg_cpu_sync_i[sel_i];
    ext_en_o = cfg_ext_sync_i[sel_i];
    next_o   = cfg_next_i[int'(sel_i)*STEP_W +: STEP_W];
    dma_en_o = dma_chan_mask(dma_code);
  end

  // single-channel codes select exactly one channel (R3)
  always_comb begin
    if (dma_code[2] === 1'b1) begin
      assert_dma_single_R3: assert ($countones(dma_en_o) == 1);
    end
  end
endmodule

// File: rtl/done_tracker.sv
module done_tracker #(
  parameter int NSRC = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clear_i,
  input  logic [NSRC-1:0] pulse_i,
  input  logic [NSRC-1:0] enable_i,
  output logic            all_done_o
);
  timeunit 1ns;
  timeprecision 100ps;

  logic [NSRC-1:0] seen_q;

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    logic seen_en;
    logic seen_d;
    always_comb begin
      seen_en = clear_i | pulse_i[i];
      seen_d  = ~clear_i;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       seen_q[i] <= 1'b0;
      else if (seen_en) seen_q[i] <= seen_d;
    end
  end

  always_comb all_done_o = &(seen_q | pulse_i | ~enable_i);

  // a clear always wins over a pulse in the same cycle (R4)
  assert_clear_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (seen_q == '0));
endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import step_seq_pkg::*;
#(
  parameter int STEP_W = 2,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              step_wr_i,
  input  logic [STEP_W-1:0] step_wdata_i,
  input  logic [CNT_W-1:0]  limit_i,
  input  logic [STEP_W-1:0] next_step_i,
  input  logic              all_done_i,
  output logic              enter_o,
  output logic              running_o,
  output logic              step_fire_o,
  output logic [STEP_W-1:0] cur_step_o,
  output logic [CNT_W-1:0]  count_o
);
  timeunit 1ns;
  timeprecision 100ps;

  seq_state_e        state_q, state_d;
  logic [STEP_W-1:0] step_q, step_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [CNT_W:0]    cnt_inc;
  logic              last_step;
  logic              step_en, cnt_en, is_idle;

  always_comb begin
    is_idle   = (state_q == SEQ_IDLE);
    cnt_inc   = {1'b0, cnt_q} + 1'b1;
    last_step = (limit_i == '0) || (cnt_inc == {1'b0, limit_i});
    state_d     = state_q;
    step_d      = step_q;
    cnt_d       = cnt_q;
    step_fire_o = 1'b0;
    case (state_q)
      SEQ_IDLE: begin
        if (step_wr_i) step_d = step_wdata_i;
        if (start_i) begin
          state_d = SEQ_ENTER;
          cnt_d   = '0;
        end
      end
      SEQ_ENTER: state_d = stop_i ? SEQ_IDLE : SEQ_WAIT;
      SEQ_WAIT: begin
        if (stop_i) begin
          state_d = SEQ_IDLE;
        end else if (all_done_i) begin
          step_fire_o = 1'b1;
          cnt_d       = cnt_inc[CNT_W-1:0];
          step_d      = next_step_i;
          state_d     = last_step ? SEQ_IDLE : SEQ_ENTER;
        end
      end
      default: state_d = SEQ_IDLE;
    endcase
    step_en = (is_idle & step_wr_i) | step_fire_o;
    cnt_en  = (is_idle & start_i) | step_fire_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SEQ_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       step_q <= '0;
    else if (step_en) step_q <= step_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  always_comb begin
    enter_o    = (state_q == SEQ_ENTER);
    running_o  = ~is_idle;
    cur_step_o = step_q;
    count_o    = cnt_q;
  end

  assert_start_enters_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!running_o && start_i) |=> (enter_o && count_o == '0));

  assert_entry_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    enter_o |=> !enter_o);

  assert_chain_next_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (step_fire_o && !last_step) |=> (enter_o && cur_step_o == $past(next_step_i)));

  assert_limit_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (step_fire_o && limit_i != '0 && cnt_inc == {1'b0, limit_i}) |=> (!running_o && count_o == $past(limit_i)));

  assert_manual_one_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (step_fire_o && limit_i == '0) |=> (!running_o && count_o == {{(CNT_W-1){1'b0}}, 1'b1}));

  assert_abort_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (running_o && stop_i) |=> (!running_o && $stable(cur_step_o)));

  assert_start_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (running_o && !enter_o && start_i && !stop_i && !all_done_i) |=> (running_o && !enter_o && $stable(count_o)));

  assert_write_ignored_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (running_o && step_wr_i && !step_fire_o) |=> $stable(cur_step_o));
endmodule

// File: rtl/step_seq.sv
module step_seq
  import step_seq_pkg::*;
#(
  parameter int  NUM_STEPS = 4,
  parameter int  NUM_ENG   = 6,
  parameter int  CNT_W     = 16,
  localparam int STEP_W    = $clog2(NUM_STEPS)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           start_i,
  input  logic                           stop_i,
  input  logic                           step_wr_i,
  input  logic [STEP_W-1:0]              step_wdata_i,
  input  logic [CNT_W-1:0]               step_limit_i,
  input  logic [NUM_STEPS*NUM_ENG-1:0]   cfg_eng_en_i,
  input  logic [NUM_STEPS*3-1:0]         cfg_dma_code_i,
  input  logic [NUM_STEPS-1:0]           cfg_cpu_sync_i,
  input  logic [NUM_STEPS-1:0]           cfg_ext_sync_i,
  input  logic [NUM_STEPS*STEP_W-1:0]    cfg_next_i,
  input  logic [NUM_ENG-1:0]             eng_done_i,
  input  logic [3:0]                     dma_done_i,
  input  logic                           cpu_done_i,
  input  logic                           ext_start_i,
  output logic                           running_o,
  output logic [STEP_W-1:0]              cur_step_o,
  output logic [CNT_W-1:0]               exec_count_o,
  output logic [NUM_ENG-1:0]             eng_start_o,
  output logic [3:0]                     dma_start_o,
  output logic                           cpu_start_o,
  output logic                           step_start_o,
  output logic                           step_done_o
);
  timeunit 1ns;
  timeprecision 100ps;

  localparam int NSRC = NUM_ENG + DMA_CH + 2;

  logic [NUM_ENG-1:0] sel_eng;
  logic [DMA_CH-1:0]  sel_dma;
  logic               sel_cpu, sel_ext;
  logic [STEP_W-1:0]  sel_next;
  logic               entering, all_done, step_fire;
  logic [NSRC-1:0]    src_pulse, src_enable;

  step_cfg_sel #(
    .NUM_STEPS(NUM_STEPS), .NUM_ENG(NUM_ENG), .STEP_W(STEP_W)
  ) u_sel (
    .sel_i          (cur_step_o),
    .cfg_eng_en_i   (cfg_eng_en_i),
    .cfg_dma_code_i (cfg_dma_code_i),
    .cfg_cpu_sync_i (cfg_cpu_sync_i),
    .cfg_ext_sync_i (cfg_ext_sync_i),
    .cfg_next_i     (cfg_next_i),
    .eng_en_o       (sel_eng),
    .dma_en_o       (sel_dma),
    .cpu_en_o       (sel_cpu),
    .ext_en_o       (sel_ext),
    .next_o         (sel_next)
  );

  always_comb begin
    src_pulse  = {ext_start_i, cpu_done_i, dma_done_i, eng_done_i};
    src_enable = {sel_ext, sel_cpu, sel_dma, sel_eng};
  end

  done_tracker #(.NSRC(NSRC)) u_done (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear_i    (entering),
    .pulse_i    (src_pulse),
    .enable_i   (src_enable),
    .all_done_o (all_done)
  );

  seq_ctrl #(.STEP_W(STEP_W), .CNT_W(CNT_W)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .stop_i       (stop_i),
    .step_wr_i    (step_wr_i),
    .step_wdata_i (step_wdata_i),
    .limit_i      (step_limit_i),
    .next_step_i  (sel_next),
    .all_done_i   (all_done),
    .enter_o      (entering),
    .running_o    (running_o),
    .step_fire_o  (step_fire),
    .cur_step_o   (cur_step_o),
    .count_o      (exec_count_o)
  );

  always_comb begin
    eng_start_o  = entering ? sel_eng : '0;
    dma_start_o  = entering ? sel_dma : '0;
    cpu_start_o  = entering & sel_cpu;
    step_start_o = entering;
    step_done_o  = step_fire;
  end

  assert_no_done_on_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
    step_start_o |-> !step_done_o);

  assert_empty_step_fast_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (step_start_o && !stop_i && src_enable == '0) |=> (step_done_o || stop_i));

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !running_o |-> (eng_start_o == '0 && dma_start_o == '0 && !cpu_start_o && !step_done_o));
endmodule

// File: tb/step_seq_tb.sv
module step_seq_tb;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int NUM_STEPS = 4;
  localparam int NUM_ENG   = 6;
  localparam int CNT_W     = 16;
  localparam int STEP_W    = 2;
  localparam int NSRC      = NUM_ENG + 6;

  logic clk = 1'b0;
  logic rst_n;
  logic start_i, stop_i, step_wr_i;
  logic [STEP_W-1:0] step_wdata_i;
  logic [CNT_W-1:0]  step_limit_i;
  logic [NUM_STEPS*NUM_ENG-1:0] cfg_eng_en_i;
  logic [NUM_STEPS*3-1:0]       cfg_dma_code_i;
  logic [NUM_STEPS-1:0]         cfg_cpu_sync_i, cfg_ext_sync_i;
  logic [NUM_STEPS*STEP_W-1:0]  cfg_next_i;
  logic [NSRC-1:0]    pv;
  logic [NUM_ENG-1:0] eng_done_i;
  logic [3:0]         dma_done_i;
  logic               cpu_done_i, ext_start_i;
  logic               running_o, cpu_start_o, step_start_o, step_done_o;
  logic [STEP_W-1:0]  cur_step_o;
  logic [CNT_W-1:0]   exec_count_o;
  logic [NUM_ENG-1:0] eng_start_o;
  logic [3:0]         dma_start_o;

  logic [NUM_ENG-1:0] eng_t [NUM_STEPS];
  logic [2:0]         dma_t [NUM_STEPS];
  logic               cpu_t [NUM_STEPS];
  logic               ext_t [NUM_STEPS];
  logic [STEP_W-1:0]  nxt_t [NUM_STEPS];

  int n_chk = 0;
  int n_fail = 0;
  int exp_cur = 0;
  bit done_flag = 1'b0;

  always #4 clk = ~clk;

  assign {ext_start_i, cpu_done_i, dma_done_i, eng_done_i} = pv;

  always_comb begin
    for (int k = 0; k < NUM_STEPS; k++) begin
      cfg_eng_en_i[k*NUM_ENG +: NUM_ENG] = eng_t[k];
      cfg_dma_code_i[k*3 +: 3]           = dma_t[k];
      cfg_cpu_sync_i[k]                  = cpu_t[k];
      cfg_ext_sync_i[k]                  = ext_t[k];
      cfg_next_i[k*STEP_W +: STEP_W]     = nxt_t[k];
    end
  end

  step_seq #(.NUM_STEPS(NUM_STEPS), .NUM_ENG(NUM_ENG), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
    .step_wr_i(step_wr_i), .step_wdata_i(step_wdata_i), .step_limit_i(step_limit_i),
    .cfg_eng_en_i(cfg_eng_en_i), .cfg_dma_code_i(cfg_dma_code_i),
    .cfg_cpu_sync_i(cfg_cpu_sync_i), .cfg_ext_sync_i(cfg_ext_sync_i),
    .cfg_next_i(cfg_next_i), .eng_done_i(eng_done_i), .dma_done_i(dma_done_i),
    .cpu_done_i(cpu_done_i), .ext_start_i(ext_start_i),
    .running_o(running_o), .cur_step_o(cur_step_o), .exec_count_o(exec_count_o),
    .eng_start_o(eng_start_o), .dma_start_o(dma_start_o), .cpu_start_o(cpu_start_o),
    .step_start_o(step_start_o), .step_done_o(step_done_o)
  );

  function automatic logic [3:0] exp_dma(input logic [2:0] c);
    case (c)
      3'd0: return 4'b0000;
      3'd1: return 4'b0011;
      3'd2: return 4'b0111;
      3'd3: return 4'b1111;
      3'd4: return 4'b0001;
      3'd5: return 4'b0010;
      3'd6: return 4'b0100;
      default: return 4'b1000;
    endcase
  endfunction

  function automatic logic [NSRC-1:0] src_mask(input int s);
    return {ext_t[s], cpu_t[s], exp_dma(dma_t[s]), eng_t[s]};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clear_cfg();
    for (int k = 0; k < NUM_STEPS; k++) begin
      eng_t[k] = '0; dma_t[k] = '0; cpu_t[k] = 1'b0; ext_t[k] = 1'b0;
      nxt_t[k] = STEP_W'(k + 1);
    end
  endtask

  // runs a sequence after the cycle in which start was driven
  task automatic run_seq(input int first, input int limit, input bit noise);
    int s;
    int cnt;
    bit fin;
    logic [NSRC-1:0] en;
    logic [NSRC-1:0] pend;
    s = first; cnt = 0; fin = 1'b0;
    while (!fin) begin
      en = src_mask(s);
      pend = en;
      @(negedge clk);
      start_i = 1'b0; step_wr_i = 1'b0;
      pv = noise ? (NSRC'($urandom) & en) : '0;
      #1;
      check("R2 running on entry", 32'(running_o), 32'd1);
      check("R6 step on entry", 32'(cur_step_o), 32'(s));
      check("R2 engine start pulses", 32'(eng_start_o), 32'(eng_t[s]));
      check("R3 dma start pulses", 32'(dma_start_o), 32'(exp_dma(dma_t[s])));
      check("R12 cpu start event", 32'(cpu_start_o), 32'(cpu_t[s]));
      check("R2 step start pulse", 32'(step_start_o), 32'd1);
      check("R4 no done on entry", 32'(step_done_o), 32'd0);
      check("R7 count during run", 32'(exec_count_o), 32'(cnt));
      for (int w = 0; w < 40; w++) begin
        @(negedge clk);
        pv = (w >= 6) ? pend : (NSRC'($urandom) & pend);
        if (noise) begin
          pv = pv | (NSRC'($urandom) & ~en);
          start_i = ($urandom % 3) == 0;
          step_wr_i = ($urandom % 3) == 0;
          step_wdata_i = STEP_W'($urandom);
        end
        #1;
        pend = pend & ~pv;
        check("R4 done when all sources seen", 32'(step_done_o), 32'(pend == '0));
        check("R10 no restart while running", 32'({step_start_o, eng_start_o}), 32'd0);
        check("R13 step held while running", 32'(cur_step_o), 32'(s));
        if (pend == '0) break;
      end
      cnt++;
      s = int'(nxt_t[s]);
      fin = (limit == 0) || (cnt == limit);
    end
    @(negedge clk);
    pv = '0; start_i = 1'b0; step_wr_i = 1'b0;
    #1;
    check("R7 R8 idle after run", 32'(running_o), 32'd0);
    check("R7 R8 final count", 32'(exec_count_o), 32'(cnt));
    check("R8 step after run", 32'(cur_step_o), 32'(s));
    exp_cur = s;
  endtask

  task automatic go(input int first, input bit write_it, input int limit, input bit noise);
    @(negedge clk);
    step_limit_i = CNT_W'(limit);
    start_i = 1'b1;
    step_wr_i = write_it;
    step_wdata_i = STEP_W'(first);
    #1;
    check("R1 idle before start", 32'(running_o), 32'd0);
    run_seq(write_it ? first : exp_cur, limit, noise);
  endtask

  initial begin
    void'($urandom(32'd20240517));
    rst_n = 1'b0; start_i = 1'b0; stop_i = 1'b0; step_wr_i = 1'b0;
    step_wdata_i = '0; step_limit_i = '0; pv = '0;
    clear_cfg();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    check("R1 reset idle", 32'(running_o), 32'd0);
    check("R1 reset step", 32'(cur_step_o), 32'd0);
    check("R1 reset count", 32'(exec_count_o), 32'd0);
    check("R1 reset pulses", 32'({eng_start_o, dma_start_o, cpu_start_o, step_start_o, step_done_o}), 32'd0);

    // R13 write while idle
    @(negedge clk); step_wr_i = 1'b1; step_wdata_i = 2'd2; #1;
    @(negedge clk); step_wr_i = 1'b0; #1;
    check("R13 idle step write", 32'(cur_step_o), 32'd2);
    exp_cur = 2;

    // R5 R8 empty step in manual mode, start at programmed step
    go(0, 1'b0, 0, 1'b0);
    check("R5 R8 manual empty step lands on next", 32'(exp_cur), 32'd3);

    // R3 every DMA code
    for (int c = 0; c < 8; c++) begin
      clear_cfg();
      dma_t[1] = 3'(c);
      go(1, 1'b1, 0, 1'b0);
    end

    // R11 R12 external and CPU handshakes, with an engine
    clear_cfg();
    ext_t[0] = 1'b1; cpu_t[1] = 1'b1; eng_t[1] = 6'b000100;
    ext_t[2] = 1'b1; cpu_t[2] = 1'b1;
    go(0, 1'b1, 3, 1'b1);

    // R6 R7 chain through a loop with limit 5
    clear_cfg();
    nxt_t[0] = 2'd2; nxt_t[2] = 2'd1; nxt_t[1] = 2'd0;
    eng_t[0] = 6'b000011; eng_t[2] = 6'b100000; dma_t[1] = 3'd2;
    go(0, 1'b1, 5, 1'b1);

    // R9 abort with a source pending, then abort while idle
    clear_cfg();
    eng_t[1] = 6'b000001; nxt_t[1] = 2'd1;
    @(negedge clk); step_limit_i = '0; start_i = 1'b1; step_wr_i = 1'b1; step_wdata_i = 2'd1; #1;
    @(negedge clk); start_i = 1'b0; step_wr_i = 1'b0; #1;
    check("R9 entered before abort", 32'(step_start_o), 32'd1);
    @(negedge clk); stop_i = 1'b1; #1;
    check("R9 no done on abort", 32'(step_done_o), 32'd0);
    @(negedge clk); stop_i = 1'b0; #1;
    check("R9 idle after abort", 32'(running_o), 32'd0);
    check("R9 step kept after abort", 32'(cur_step_o), 32'd1);
    check("R9 count after abort", 32'(exec_count_o), 32'd0);
    @(negedge clk); stop_i = 1'b1; #1;
    @(negedge clk); stop_i = 1'b0; #1;
    check("R9 idle abort no effect running", 32'(running_o), 32'd0);
    check("R9 idle abort no effect step", 32'(cur_step_o), 32'd1);
    exp_cur = 1;
    go(0, 1'b0, 0, 1'b0);

    // random chains
    for (int it = 0; it < 40; it++) begin
      for (int k = 0; k < NUM_STEPS; k++) begin
        eng_t[k] = NUM_ENG'($urandom & $urandom);
        dma_t[k] = ($urandom % 2) ? 3'($urandom) : 3'd0;
        cpu_t[k] = ($urandom % 4) == 0;
        ext_t[k] = ($urandom % 4) == 0;
        nxt_t[k] = STEP_W'($urandom);
      end
      go(int'($urandom % NUM_STEPS), ($urandom % 2) == 1, int'($urandom % 7), 1'b1);
    end

    done_flag = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_flag) begin
      n_fail++;
      $display("FAIL watchdog R1 actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule